// File: doc/BRIEF.md
# Fractional-N Divider Controller

This block turns a stream of input enables (one per cycle of a fast prescaled clock) into a divided output pulse, one per output period. The length of each period, counted in accepted enables, is reloaded at the end of the previous period. The new length is the integer setting plus a signed offset from a cascade of first-order 16-bit accumulators (a MASH noise shaper) whose fractional input is a numerator over 2^16. Because the length changes from one period to the next, the long-run average division ratio is N + F/2^16. The comparison rate therefore stays high while the tuning step becomes fine. The chosen modulator order (2, 3 or 4) sets how many distinct divisors appear. A higher order spreads the dither over more values and moves the quantisation error away from the carrier.

The controller is a two-state machine. `ST_START` is the load state entered from reset. It steps the noise shaper once, loads the first period length, and always takes the transition `START->RUN`. `ST_RUN` counts accepted enables down. On the terminal enable it takes the transition `RUN->RUN (reload)`: it pulses the output, steps the shaper and loads the next length. In all other cycles it takes `RUN->RUN (count)`, and it holds when no enable is present. If `N` is below the smallest value the chosen order can tolerate, `N` is raised to that floor before the offset is added.

Top module: `fracn_divider`

## Requirements
- R1: While reset is asserted `div_pulse` is low. Reset clears all noise-shaper state, so with a zero fraction the first period after reset is exactly N enables long.
- R2: With `div_frac` = 0, every output period is exactly N accepted enables long, for any order.
- R3: Only cycles with `in_en` high advance the period count. The first clock after reset release is the load cycle, and its `in_en` is ignored. `div_pulse` is high for exactly one cycle: the cycle after the clock that accepted the terminal enable.
- R4: With `mod_order` = 2 (binary code 3'd2), every period length lies in N-1..N+2, and at most 4 distinct lengths occur.
- R5: With `mod_order` = 3 (3'd3), every period length lies in N-3..N+4, and at most 8 distinct lengths occur.
- R6: With `mod_order` = 4 (3'd4), every period length lies in N-7..N+8, and at most 16 distinct lengths occur.
- R7: For the first K periods after reset, the total number of accepted enables differs from N·K + K·F/2^16 by at most 2^(order-2) enables (1, 2 or 4).
- R8: Any `mod_order` code other than 2, 3 or 4 behaves as order 2.
- R9: An N below 2^(order-1)+1 (3, 5 or 9 for orders 2, 3, 4) is replaced by that floor. No loaded period is shorter than 2 enables.
- R10: `div_int`, `div_frac` and `mod_order` are sampled only when a new period length is loaded. A change during a period alters the following period, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Input pulse qualifier; each high cycle is one input pulse |
| div_int | input | 16 | Integer divisor N |
| div_frac | input | 16 | Fractional numerator F over 2^16 |
| mod_order | input | 3 | Noise-shaper order code (2, 3 or 4) |
| div_pulse | output | 1 | One-cycle pulse marking the end of each output period |

## Verification
`div_pulse` rises one cycle after the rising edge that accepts the terminal enable. The bench therefore samples on the falling edge and first credits the enable it drove before the preceding rising edge to the running period, then looks at the pulse. The first rising edge after reset release is the load cycle, so the bench holds `in_en` low through it. Settings take effect only at the reload that ends the current period, so the mid-period change test expects the old length for the period in progress and the new length for the next one. Range, distinct-length and cumulative-count checks are made once each long window has closed, on statistics gathered from every period.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_RUN   = 1'b1
    } fsm_state_t;

    // Binomial coefficient used for the noise-shaping difference weights
    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * (n - i) / (i + 1);
        end
        return r;
    endfunction

    // Illegal order codes fall back to second order
    function automatic int order_eff(input int sel, input int max_ord);
        return (sel >= 2 && sel <= max_ord) ? sel : 2;
    endfunction

    function automatic int ofs_lo(input int ord);
        return 1 - (1 << (ord - 1));
    endfunction

    function automatic int ofs_hi(input int ord);
        return 1 << (ord - 1);
    endfunction

    // Smallest N that keeps N + ofs_lo at 2 or more
    function automatic int n_floor(input int ord);
        return (1 << (ord - 1)) + 1;
    endfunction

endpackage

// File: rtl/fracn_mash_stage.sv
module fracn_mash_stage #(
    parameter int ACC_W = 16,
    parameter int DIFF  = 0,
    parameter int OFS_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [ACC_W-1:0]        din,
    output logic [ACC_W-1:0]        sum_nxt,
    output logic signed [OFS_W-1:0] term
);
    import fracn_pkg::*;

    logic [ACC_W-1:0] acc_q;
    logic             carry;

    assign {carry, sum_nxt} = {1'b0, acc_q} + {1'b0, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= sum_nxt;
        end
    end

    generate
        if (DIFF == 0) begin : g_first
            assign term = {{(OFS_W-1){1'b0}}, carry};
        end else begin : g_shape
            logic [DIFF-1:0] hist_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (adv) begin
                    hist_q <= DIFF'({hist_q, carry});
                end
            end

            // DIFF-th backward difference of the carry stream
            always_comb begin
                int t;
                t = int'(carry);
                for (int k = 1; k <= DIFF; k++) begin
                    if (hist_q[k-1]) begin
                        t = t + (((k % 2) == 1) ? -binom(DIFF, k) : binom(DIFF, k));
                    end
                end
                term = OFS_W'(t);
            end
        end
    endgenerate

endmodule

// File: rtl/fracn_mash.sv
module fracn_mash #(
    parameter int ACC_W     = 16,
    parameter int MAX_ORDER = 4,
    parameter int SEL_W     = 3,
    parameter int OFS_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [ACC_W-1:0]        frac,
    input  logic [SEL_W-1:0]        order_sel,
    output logic signed [OFS_W-1:0] ofs
);
    import fracn_pkg::*;

    logic [ACC_W-1:0]        chain [MAX_ORDER+1];
    logic signed [OFS_W-1:0] terms [MAX_ORDER];
    int                      ord;

    assign chain[0] = frac;
    assign ord      = order_eff(int'(order_sel), MAX_ORDER);

    generate
        for (genvar j = 0; j < MAX_ORDER; j++) begin : g_stage
            fracn_mash_stage #(
                .ACC_W (ACC_W),
                .DIFF  (j),
                .OFS_W (OFS_W)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv),
                .din     (chain[j]),
                .sum_nxt (chain[j+1]),
                .term    (terms[j])
            );
        end
    endgenerate

    always_comb begin
        int s;
        s = 0;
        for (int j = 0; j < MAX_ORDER; j++) begin
            if (j < ord) begin
                s = s + int'(terms[j]);
            end
        end
        ofs = OFS_W'(s);
    end

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (int'(ofs) >= ofs_lo(ord) && int'(ofs) <= ofs_hi(ord))); // R4 R5 R6 R8

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [DIV_W-1:0] div_load,
    output logic             adv,
    output logic             div_pulse
);
    import fracn_pkg::*;

    fsm_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             term_hit;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        adv      = 1'b0;
        term_hit = 1'b0;
        unique case (state_q)
            ST_START: begin
                adv     = 1'b1;
                cnt_d   = div_load - DIV_W'(1);
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (in_en) begin
                    if (cnt_q == '0) begin
                        term_hit = 1'b1;
                        adv      = 1'b1;
                        cnt_d    = div_load - DIV_W'(1);
                    end else begin
                        cnt_d = cnt_q - DIV_W'(1);
                    end
                end
            end
            default: state_d = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= term_hit;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R3
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(in_en)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !in_en) |=> $stable(cnt_q)); // R3
    AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (div_load >= DIV_W'(2))); // R9

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider #(
    parameter int N_W       = 16,
    parameter int F_W       = 16,
    parameter int SEL_W     = 3,
    parameter int MAX_ORDER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [N_W-1:0]   div_int,
    input  logic [F_W-1:0]   div_frac,
    input  logic [SEL_W-1:0] mod_order,
    output logic             div_pulse
);
    import fracn_pkg::*;

    localparam int OFS_W = MAX_ORDER + 1;
    localparam int DIV_W = N_W + 1;

    logic signed [OFS_W-1:0] ofs;
    logic [DIV_W-1:0]        div_load;
    logic                    adv;
    int                      ord;

    assign ord = order_eff(int'(mod_order), MAX_ORDER);

    fracn_mash #(
        .ACC_W     (F_W),
        .MAX_ORDER (MAX_ORDER),
        .SEL_W     (SEL_W),
        .OFS_W     (OFS_W)
    ) u_mash (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .frac      (div_frac),
        .order_sel (mod_order),
        .ofs       (ofs)
    );

    // Clamp N to the order's floor, then add the shaped offset
    always_comb begin
        int n_eff;
        n_eff = int'(div_int);
        if (n_eff < n_floor(ord)) begin
            n_eff = n_floor(ord);
        end
        div_load = DIV_W'(n_eff + int'(ofs));
    end

    fracn_div_ctrl #(
        .DIV_W (DIV_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_en     (in_en),
        .div_load  (div_load),
        .adv       (adv),
        .div_pulse (div_pulse)
    );

endmodule

// File: tb/fracn_divider_bench.sv
module fracn_divider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_en = 1'b0;
    logic [15:0] div_int = 16'd4;
    logic [15:0] div_frac = 16'd0;
    logic [2:0]  mod_order = 3'd2;
    logic        div_pulse;

    int     checks = 0;
    int     failures = 0;
    int     cyc = 0;
    bit     en_q = 1'b0;
    bit     last_pulse = 1'b0;
    int     pct = 100;
    int     run = 0;
    int     per_cnt, pmin, pmax, first_per, p_prev, p_last, ne_cur;
    longint tot;
    bit [31:0] seen;

    fracn_divider u_fracn_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_en     (in_en),
        .div_int   (div_int),
        .div_frac  (div_frac),
        .mod_order (mod_order),
        .div_pulse (div_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_ord(input int o);
        return (o >= 2 && o <= 4) ? o : 2;
    endfunction

    function automatic int eff_n(input int n, input int oe);
        int fl;
        fl = (1 << (oe - 1)) + 1;
        return (n < fl) ? fl : n;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic record(input int p);
        int idx;
        per_cnt++;
        tot += p;
        if (per_cnt == 1) first_per = p;
        if (p < pmin) pmin = p;
        if (p > pmax) pmax = p;
        p_prev = p_last;
        p_last = p;
        idx = p - ne_cur + 8;
        if (idx < 0) idx = 0;
        if (idx > 31) idx = 31;
        seen[idx] = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
        run += int'(en_q);
        if (div_pulse) begin
            if (last_pulse || !en_q)
                check(1'b0, "R3", "pulse width or cause", int'(last_pulse), 0);
            record(run);
            run = 0;
        end
        last_pulse = div_pulse;
        en_q = (($urandom % 100) < pct);
        in_en = en_q;
    endtask

    task automatic do_reset(input int n, input int f, input int o);
        @(negedge clk);
        rst_n = 1'b0;
        in_en = 1'b0;
        en_q = 1'b0;
        div_int = 16'(n);
        div_frac = 16'(f);
        mod_order = 3'(o);
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R1", "pulse during reset", div_pulse, 0);
        rst_n = 1'b1;
        run = 0;
        last_pulse = 1'b0;
        per_cnt = 0;
        tot = 0;
        pmin = 1 << 30;
        pmax = 0;
        first_per = 0;
        p_prev = 0;
        p_last = 0;
        seen = '0;
        ne_cur = eff_n(n, eff_ord(o));
    endtask

    task automatic run_until(input int k);
        while (per_cnt < k) step();
    endtask

    task automatic check_window(input string rq, input int n, input int f,
                                input int o, input int k);
        int oe, ne, lo, hi;
        longint dev, bound;
        oe = eff_ord(o);
        ne = eff_n(n, oe);
        lo = (1 << (oe - 1)) - 1;
        hi = 1 << (oe - 1);
        check(pmin >= ne - lo, rq, "shortest period", pmin, ne - lo);
        check(pmax <= ne + hi, rq, "longest period", pmax, ne + hi);
        check($countones(seen) <= (1 << oe), rq, "distinct lengths",
              $countones(seen), 1 << oe);
        dev = tot * 65536 - (longint'(ne) * k * 65536 + longint'(k) * f);
        if (dev < 0) dev = -dev;
        bound = longint'(1 << (oe - 2)) * 65536;
        check(dev <= bound, "R7", "cumulative deviation x65536", dev, bound);
    endtask

    task automatic int_case(input string rq, input int n, input int o,
                            input int p, input int expn);
        pct = p;
        do_reset(n, 0, o);
        run_until(12);
        check(first_per == expn, "R1", "first period", first_per, expn);
        check(pmin == expn && pmax == expn, rq, "integer period", pmin, expn);
    endtask

    task automatic frac_case(input string rq, input int n, input int f,
                             input int o, input int p, input int k);
        pct = p;
        do_reset(n, f, o);
        run_until(k);
        check_window(rq, n, f, o, k);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd13579);

        // Integer mode, several N and enable densities
        int_case("R2", 5, 2, 100, 5);
        int_case("R2", 13, 3, 60, 13);
        int_case("R3", 7, 4, 35, 9);
        int_case("R2", 40, 4, 90, 40);

        // Floors per order
        int_case("R9", 1, 2, 100, 3);
        int_case("R9", 4, 3, 100, 5);
        int_case("R9", 2, 4, 80, 9);

        // Random fractions per order
        frac_case("R4", 20, int'(($urandom & 16'hFFFF) | 1), 2, 80, 1000);
        frac_case("R5", 20, int'(($urandom & 16'hFFFF) | 1), 3, 80, 1000);
        frac_case("R6", 20, int'(($urandom & 16'hFFFF) | 1), 4, 80, 1000);

        // Directed fraction corners
        frac_case("R6", 12, 1, 4, 100, 300);
        frac_case("R6", 12, 16'hFFFF, 4, 100, 300);
        frac_case("R4", 6, 16'h8000, 2, 100, 300);
        frac_case("R9", 3, 16'h5A5A, 4, 100, 300);

        // Illegal order codes fall back to order 2
        frac_case("R8", 20, int'(($urandom & 16'hFFFF) | 1), 7, 80, 400);
        frac_case("R8", 20, 16'h3333, 0, 80, 400);

        // Mid-period setting change
        pct = 100;
        do_reset(10, 0, 2);
        run_until(2);
        step();
        step();
        step();
        div_int = 16'd7;
        run_until(4);
        check(p_prev == 10, "R10", "period in progress at change", p_prev, 10);
        check(p_last == 7, "R10", "period after change", p_last, 7);

        summary();
        $finish;
    end

endmodule